// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Generator

This block produces the data address for signal-processing loops. In ring mode it holds a pointer that moves inside a circular buffer, described by a base address and a length. Each step command advances or retreats the pointer by one, and the pointer wraps around at either end of the buffer without any software help. Software loads the buffer geometry once, and the loop then issues only step commands.

In reverse mode the block keeps a separate linear counter with a programmable width. It emits that counter with its bits mirrored, which is the reordering an FFT needs for its input or output. The address bits above the programmed width come from the base address. The active mode is chosen by a mode input. The state of the inactive mode is held, so a loop can switch between the two mode sequences and continue each from where it stopped.

Top module: `agu_modrev`

## Requirements
- R1: A synchronous active-high reset sets the output address to 0, the base to 0, the buffer length to 1, the reverse width to 1, and both the pointer and the reverse counter to 0.
- R2: In ring mode (`mode`=0), `step_up` alone moves the pointer up by one. When the pointer is at the last entry (base+length-1), it moves to the base instead. `addr_out` shows the new pointer after the first rising edge following the command.
- R3: In ring mode, `step_dn` alone moves the pointer down by one. When the pointer is at the base, it moves to base+length-1 instead.
- R4: `step_up` and `step_dn` asserted in the same cycle leave the pointer and the reverse counter unchanged.
- R5: `base_ld` loads the base, moves the pointer to the new base, and clears the reverse counter. This overrides any step command in the same cycle. `len_ld` changes only the buffer length and leaves the pointer where it is. A length of 0 is taken as 1.
- R6: In reverse mode (`mode`=1), the steps move a W-bit counter up or down modulo 2^W. `addr_out` equals the base with its low W bits replaced by the counter reversed over W bits. For W=3 the low bits run 0,4,2,6,1,5,3,7.
- R7: `wid_ld` loads W from `wid_in` and clears the reverse counter. A value of 0 loads as 1, and a value above 10 loads as 10.
- R8: Only the state of the selected mode steps; the other mode's state holds. A change of `mode` shows the other mode's address after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_ld | input | 1 | Load base address, reset pointer and counter |
| base_in | input | ADDR_W (16) | New base address |
| len_ld | input | 1 | Load buffer length |
| len_in | input | ADDR_W (16) | New buffer length |
| wid_ld | input | 1 | Load reverse width |
| wid_in | input | 4 | New reverse width, 1 to 10 |
| mode | input | 1 | 0 ring, 1 bit-reversed |
| step_up | input | 1 | Advance command |
| step_dn | input | 1 | Retreat command |
| addr_out | output | ADDR_W (16) | Registered current address |

## Verification
Every result in this block is due at the first rising edge after its stimulus. This holds for steps, loads and mode changes, because the output register captures the next-state address directly. The bench applies each command just after a falling edge and reads `addr_out` at the following falling edge. At that point exactly one rising edge has passed, and an arithmetic model has been advanced by the same command. Ring wraps are swept in both directions across a small buffer, and every reverse width from 1 to 10 is walked through its full sequence.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  typedef enum logic {
    MODE_RING    = 1'b0,
    MODE_REVERSE = 1'b1
  } mode_e;

  // Opposing commands cancel.
  function automatic step_e step_decode(input logic up, input logic down);
    case ({up, down})
      2'b10:   return STEP_UP;
      2'b01:   return STEP_DOWN;
      default: return STEP_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/agu_cfg.sv
module agu_cfg #(
  parameter int ADDR_W  = 16,
  parameter int REV_MAX = 10,
  localparam int WID_W  = $clog2(REV_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_ld,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              len_ld,
  input  logic [ADDR_W-1:0] len_in,
  input  logic              wid_ld,
  input  logic [WID_W-1:0]  wid_in,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] base_n,
  output logic [ADDR_W-1:0] last_q,
  output logic [WID_W-1:0]  width_q,
  output logic [WID_W-1:0]  width_n,
  output logic [ADDR_W-1:0] mask_n
);

  logic [ADDR_W-1:0] len_r, len_n, last_n;

  function automatic logic [WID_W-1:0] clamp_width(input logic [WID_W-1:0] w);
    if (w == '0)                 return WID_W'(1);
    else if (w > WID_W'(REV_MAX)) return WID_W'(REV_MAX);
    else                         return w;
  endfunction

  always_comb begin
    base_n  = base_ld ? base_in : base_q;
    len_n   = len_r;
    if (len_ld) len_n = (len_in == '0) ? ADDR_W'(1) : len_in;
    // End of buffer is precomputed here so the step path only compares.
    last_n  = base_n + len_n - ADDR_W'(1);
    width_n = wid_ld ? clamp_width(wid_in) : width_q;
    mask_n  = (ADDR_W'(1) << width_n) - ADDR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      len_r   <= ADDR_W'(1);
      last_q  <= '0;
      width_q <= WID_W'(1);
    end else begin
      base_q  <= base_n;
      len_r   <= len_n;
      last_q  <= last_n;
      width_q <= width_n;
    end
  end

endmodule

// File: rtl/agu_ring.sv
module agu_ring
  import agu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  step_e             step,
  input  logic              reload,
  input  logic [ADDR_W-1:0] reload_val,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [ADDR_W-1:0] last_q,
  output logic [ADDR_W-1:0] ptr_q,
  output logic [ADDR_W-1:0] ptr_n
);

  always_comb begin
    ptr_n = ptr_q;
    if (reload) begin
      ptr_n = reload_val;
    end else if (active) begin
      case (step)
        STEP_UP:   ptr_n = (ptr_q == last_q) ? base_q : ptr_q + ADDR_W'(1);
        STEP_DOWN: ptr_n = (ptr_q == base_q) ? last_q : ptr_q - ADDR_W'(1);
        default:   ptr_n = ptr_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= ptr_n;
  end

endmodule

// File: rtl/agu_bitrev.sv
module agu_bitrev
  import agu_pkg::*;
#(
  parameter int REV_MAX = 10,
  localparam int WID_W  = $clog2(REV_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               active,
  input  step_e              step,
  input  logic               clear,
  input  logic [WID_W-1:0]   width_q,
  input  logic [WID_W-1:0]   width_n,
  output logic [REV_MAX-1:0] cnt_q,
  output logic [REV_MAX-1:0] rev_n
);

  logic [REV_MAX-1:0] cnt_n, cmask, mirror;
  logic [WID_W-1:0]   shamt;

  always_comb begin
    cmask = (REV_MAX'(1) << width_q) - REV_MAX'(1);
    cnt_n = cnt_q;
    if (clear) begin
      cnt_n = '0;
    end else if (active) begin
      case (step)
        STEP_UP:   cnt_n = (cnt_q + REV_MAX'(1)) & cmask;
        STEP_DOWN: cnt_n = (cnt_q - REV_MAX'(1)) & cmask;
        default:   cnt_n = cnt_q;
      endcase
    end
  end

  // Full-width mirror, then a right shift aligns it to the programmed width.
  for (genvar i = 0; i < REV_MAX; i++) begin : g_mirror
    assign mirror[i] = cnt_n[REV_MAX-1-i];
  end

  assign shamt = WID_W'(REV_MAX) - width_n;
  assign rev_n = mirror >> shamt;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_n;
  end

endmodule

// File: rtl/agu_modrev.sv
module agu_modrev
  import agu_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int REV_MAX = 10,
  localparam int WID_W  = $clog2(REV_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_ld,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              len_ld,
  input  logic [ADDR_W-1:0] len_in,
  input  logic              wid_ld,
  input  logic [WID_W-1:0]  wid_in,
  input  logic              mode,
  input  logic              step_up,
  input  logic              step_dn,
  output logic [ADDR_W-1:0] addr_out
);

  mode_e              mode_sel;
  step_e              step;
  logic [ADDR_W-1:0]  base_q, base_n, last_q, mask_n, ptr_q, ptr_n, addr_n;
  logic [WID_W-1:0]   width_q, width_n;
  logic [REV_MAX-1:0] cnt_q, rev_n;

  assign mode_sel = mode_e'(mode);
  assign step     = step_decode(step_up, step_dn);

  agu_cfg #(.ADDR_W(ADDR_W), .REV_MAX(REV_MAX)) i_cfg (
    .clk     (clk),
    .rst     (rst),
    .base_ld (base_ld),
    .base_in (base_in),
    .len_ld  (len_ld),
    .len_in  (len_in),
    .wid_ld  (wid_ld),
    .wid_in  (wid_in),
    .base_q  (base_q),
    .base_n  (base_n),
    .last_q  (last_q),
    .width_q (width_q),
    .width_n (width_n),
    .mask_n  (mask_n)
  );

  agu_ring #(.ADDR_W(ADDR_W)) i_ring (
    .clk        (clk),
    .rst        (rst),
    .active     (mode_sel == MODE_RING),
    .step       (step),
    .reload     (base_ld),
    .reload_val (base_in),
    .base_q     (base_q),
    .last_q     (last_q),
    .ptr_q      (ptr_q),
    .ptr_n      (ptr_n)
  );

  agu_bitrev #(.REV_MAX(REV_MAX)) i_bitrev (
    .clk     (clk),
    .rst     (rst),
    .active  (mode_sel == MODE_REVERSE),
    .step    (step),
    .clear   (base_ld | wid_ld),
    .width_q (width_q),
    .width_n (width_n),
    .cnt_q   (cnt_q),
    .rev_n   (rev_n)
  );

  // Output register captures the next-state address: one edge of latency.
  always_comb begin
    if (mode_sel == MODE_REVERSE) addr_n = (base_n & ~mask_n) | ADDR_W'(rev_n);
    else                          addr_n = ptr_n;
  end

  always_ff @(posedge clk) begin
    if (rst) addr_out <= '0;
    else     addr_out <= addr_n;
  end

endmodule

// File: rtl/agu_modrev_chk.sv
module agu_modrev_chk #(
  parameter int ADDR_W  = 16,
  parameter int REV_MAX = 10,
  localparam int WID_W  = $clog2(REV_MAX + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               base_ld,
  input logic [ADDR_W-1:0]  base_in,
  input logic               wid_ld,
  input logic               mode,
  input logic               step_up,
  input logic               step_dn,
  input logic [ADDR_W-1:0]  addr_out,
  input logic [ADDR_W-1:0]  ptr_q,
  input logic [REV_MAX-1:0] cnt_q,
  input logic [ADDR_W-1:0]  base_q,
  input logic [ADDR_W-1:0]  last_q,
  input logic [WID_W-1:0]   width_q
);

  a_r1_reset_addr: assert property (@(posedge clk) rst |=> addr_out == '0);

  a_r2_up_wrap: assert property (@(posedge clk) disable iff (rst)
    (!mode && step_up && !step_dn && !base_ld && ptr_q == last_q) |=> ptr_q == $past(base_q));

  a_r3_down_wrap: assert property (@(posedge clk) disable iff (rst)
    (!mode && step_dn && !step_up && !base_ld && ptr_q == base_q) |=> ptr_q == $past(last_q));

  a_r4_cancel_hold: assert property (@(posedge clk) disable iff (rst)
    (step_up && step_dn && !base_ld && !wid_ld) |=> ($stable(ptr_q) && $stable(cnt_q)));

  a_r5_base_reload: assert property (@(posedge clk) disable iff (rst)
    base_ld |=> (ptr_q == $past(base_in) && cnt_q == '0));

  a_r6_upper_from_base: assert property (@(posedge clk) disable iff (rst)
    (mode && !base_ld && !wid_ld) |=> (((addr_out ^ base_q) >> width_q) == '0));

  a_r7_width_range: assert property (@(posedge clk) disable iff (rst)
    (width_q != '0 && width_q <= WID_W'(REV_MAX)));

  a_r7_width_clears: assert property (@(posedge clk) disable iff (rst)
    wid_ld |=> cnt_q == '0);

  a_r8_ring_idle: assert property (@(posedge clk) disable iff (rst)
    (mode && !base_ld) |=> $stable(ptr_q));

  a_r8_rev_idle: assert property (@(posedge clk) disable iff (rst)
    (!mode && !base_ld && !wid_ld) |=> $stable(cnt_q));

endmodule

bind agu_modrev agu_modrev_chk #(.ADDR_W(ADDR_W), .REV_MAX(REV_MAX)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .base_ld  (base_ld),
  .base_in  (base_in),
  .wid_ld   (wid_ld),
  .mode     (mode),
  .step_up  (step_up),
  .step_dn  (step_dn),
  .addr_out (addr_out),
  .ptr_q    (ptr_q),
  .cnt_q    (cnt_q),
  .base_q   (base_q),
  .last_q   (last_q),
  .width_q  (width_q)
);

// File: tb/test_agu_modrev.sv
`timescale 1ns/1ps
module test_agu_modrev;

  localparam int ADDR_W  = 16;
  localparam int REV_MAX = 10;
  localparam int WID_W   = $clog2(REV_MAX + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              base_ld = 1'b0, len_ld = 1'b0, wid_ld = 1'b0;
  logic [ADDR_W-1:0] base_in = '0, len_in = '0;
  logic [WID_W-1:0]  wid_in = '0;
  logic              mode = 1'b0, step_up = 1'b0, step_dn = 1'b0;
  logic [ADDR_W-1:0] addr_out;

  int tests = 0, fails = 0;
  int m_base = 0, m_len = 1, m_w = 1, m_ptr = 0, m_cnt = 0, m_mode = 0;

  always #2 clk = ~clk;

  agu_modrev #(.ADDR_W(ADDR_W), .REV_MAX(REV_MAX)) i_agu_modrev (
    .clk(clk), .rst(rst), .base_ld(base_ld), .base_in(base_in),
    .len_ld(len_ld), .len_in(len_in), .wid_ld(wid_ld), .wid_in(wid_in),
    .mode(mode), .step_up(step_up), .step_dn(step_dn), .addr_out(addr_out)
  );

  function automatic int rev_bits(input int c, input int w);
    int r = 0;
    for (int i = 0; i < w; i++) if (((c >> i) & 1) != 0) r += 1 << (w - 1 - i);
    return r;
  endfunction

  function automatic int exp_addr();
    if (m_mode == 1) return (((m_base >> m_w) << m_w) + rev_bits(m_cnt, m_w)) & 16'hFFFF;
    return m_ptr;
  endfunction

  task automatic check(input string tag, input int exp);
    tests++;
    if (int'(addr_out) != exp) begin
      fails++;
      $display("FAIL %s: addr_out=%0d expected %0d", tag, addr_out, exp);
    end
  endtask

  // Called just after a falling edge; returns at the next falling edge.
  task automatic apply(input bit up, input bit dn, input bit bl, input int bv,
                       input bit ll, input int lv, input bit wl, input int wv, input int md);
    int last = m_base + m_len - 1;
    step_up = up; step_dn = dn; base_ld = bl; base_in = ADDR_W'(bv);
    len_ld = ll; len_in = ADDR_W'(lv); wid_ld = wl; wid_in = WID_W'(wv); mode = md[0];
    @(negedge clk);
    step_up = 0; step_dn = 0; base_ld = 0; len_ld = 0; wid_ld = 0;
    m_mode = md;
    if (!bl && up != dn) begin
      if (md == 0) begin
        if (up) m_ptr = (m_ptr == last) ? m_base : m_ptr + 1;
        else    m_ptr = (m_ptr == m_base) ? last : m_ptr - 1;
      end else if (!wl) begin
        if (up) m_cnt = (m_cnt + 1) % (1 << m_w);
        else    m_cnt = (m_cnt + (1 << m_w) - 1) % (1 << m_w);
      end
    end
    if (bl) begin m_base = bv; m_ptr = bv; m_cnt = 0; end
    if (ll) m_len = (lv == 0) ? 1 : lv;
    if (wl) begin m_w = (wv == 0) ? 1 : (wv > REV_MAX ? REV_MAX : wv); m_cnt = 0; end
  endtask

  task automatic step(input bit up, input bit dn);
    apply(up, dn, 0, 0, 0, 0, 0, 0, m_mode);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: addr_out=%0d expected completion", addr_out);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int order [8] = '{0, 4, 2, 6, 1, 5, 3, 7};
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset address", 0);
    step(1, 0);
    check("R1 R2 default length 1 wraps in place", exp_addr());

    // Ring mode: base 100, length 5
    apply(0, 0, 1, 100, 1, 5, 0, 0, 0);
    check("R5 base load sets pointer", 100);
    for (int k = 0; k < 12; k++) begin
      step(1, 0);
      check("R2 ring increment/wrap", exp_addr());
    end
    check("R2 literal position after 12 steps", 102);
    for (int k = 0; k < 12; k++) begin
      step(0, 1);
      check("R3 ring decrement/wrap", exp_addr());
    end
    check("R3 literal position back at start", 100);
    step(0, 1);
    check("R3 below base wraps to last", 104);
    step(1, 1);
    check("R4 opposing steps hold", 104);
    apply(1, 1, 0, 0, 0, 0, 0, 0, 1);
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R4 counter untouched by opposing steps", 104);
    apply(0, 0, 0, 0, 1, 3, 0, 0, 0);
    check("R5 length load keeps pointer", 104);
    apply(1, 0, 1, 200, 0, 0, 0, 0, 0);
    check("R5 base load overrides step", 200);
    step(1, 0); step(1, 0); step(1, 0);
    check("R5 new length 3 wraps at 202", 200);
    apply(0, 0, 0, 0, 1, 0, 0, 0, 0);
    step(1, 0);
    check("R5 length 0 behaves as 1", 200);

    // Reverse mode, base with upper bits set
    apply(0, 0, 1, 16'hA5C3, 1, 4, 0, 0, 1);
    for (int w = 1; w <= REV_MAX; w++) begin
      apply(0, 0, 0, 0, 0, 0, 1, w, 1);
      check("R7 width load clears counter", exp_addr());
      for (int k = 0; k < (1 << w); k++) begin
        step(1, 0);
        check("R6 reversed sweep", exp_addr());
      end
      for (int k = 0; k < 3; k++) begin
        step(0, 1);
        check("R6 reversed decrement", exp_addr());
      end
    end

    apply(0, 0, 1, 16'h0040, 0, 0, 1, 3, 1);
    for (int k = 0; k < 8; k++) begin
      check("R6 eight-entry order", 16'h0040 + order[k]);
      step(1, 0);
    end
    check("R6 order wraps to start", 16'h0040);

    apply(0, 0, 0, 0, 0, 0, 1, 0, 1);
    step(1, 0);
    check("R7 width 0 loads as 1", 16'h0041);
    apply(0, 0, 0, 0, 0, 0, 1, 15, 1);
    step(1, 0);
    check("R7 width 15 loads as 10", 16'h0200);

    // Mode independence
    step(1, 0);
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R8 ring pointer held during reverse steps", 16'h0040);
    step(1, 0); step(1, 0);
    check("R8 ring steps in ring mode", exp_addr());
    apply(0, 0, 0, 0, 0, 0, 0, 0, 1);
    check("R8 reverse counter held during ring steps", 16'h0100);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule